// File: doc/BRIEF.md
# Interrupt Pending Post/Clear Register

This block keeps a small set of posted-interrupt flags for one group of interrupt sources. There is one wake source and five endpoint sources. A single-cycle pulse on a hardware event input sets the matching flag. Software reads the register through a simple register port to see which flags are pending. The flag vector also goes out continuously to a downstream interrupt controller.

A separate software-interrupt enable input decides what a write does. When the enable is low, a write acts as a clear with inverted polarity: every bit written as 0 drops its pending flag, and every bit written as 1 leaves its flag alone. When the enable is high, a write posts interrupts: every bit written as 1 sets its flag, and every bit written as 0 leaves its flag alone. If a hardware event and a software clear reach the same bit in the same cycle, the event wins, so no event is lost.

Top module: `irq_post_clr_reg`

## Requirements
- R1: After the asynchronous active-low reset, all six pending flags are 0. Both the read data and the pending output read 0x00.
- R2: The byte layout is as follows. Bit 5 holds the wake source. Bits 4 down to 0 hold endpoint sources 8 down to 4, so bit 0 is endpoint 4. Bits 7 and 6 always read 0, whatever value is written to them.
- R3: Reading the register address returns the pending flags in the R2 layout, in the same cycle as the address. Reading any other address returns 0x00. A read never changes a flag.
- R4: A write with the enable low clears each flag whose data bit is 0. The flags change on the clock edge where the write strobe is high and the address matches.
- R5: A write with the enable low leaves unchanged every flag whose data bit is 1.
- R6: A write with the enable high leaves unchanged every flag whose data bit is 0.
- R7: A write with the enable high sets each flag whose data bit is 1.
- R8: A one-cycle pulse on an event input sets its flag on that clock edge, whatever write activity happens in the same cycle. When an event and a clear hit the same bit, the set wins.
- R9: A write to an address other than the register address changes no flag.
- R10: The pending output always equals the six flags. Bit 5 is wake and bit 0 is endpoint 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| sw_post_en | input | 1 | High: writes post interrupts. Low: writes clear flags. |
| wake_evt | input | 1 | Wake event pulse |
| ep_evt | input | 5 | Endpoint event pulses, bit 0 is endpoint 4 |
| irq_pending | output | 6 | Pending vector to the interrupt controller |

## Verification
The bench writes mixed data patterns under both enable states. A design with the clear polarity inverted would drop flags that were written as 1. A design that ignores the enable would post interrupts while in clear mode, or clear flags while in post mode. The bench also fires events in the same cycle as a clearing write that targets the same bits; a design where the clear wins would lose those events. It writes ones to bits 7 and 6, and it writes and reads at wrong addresses. A design that stored the reserved bits, or decoded the address loosely, would show them in the read data or change the flags.

// File: rtl/irq_post_clr_pkg.sv
package irq_post_clr_pkg;
  parameter int unsigned DATA_W = 8;
  parameter int unsigned ADDR_W = 8;
  parameter int unsigned N_EP   = 5;
  parameter int unsigned N_SRC  = N_EP + 1;
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hDC;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_CLEAR = 2'b01,
    OP_POST  = 2'b10
  } wr_op_e;
endpackage

// File: rtl/irq_wr_decode.sv
module irq_wr_decode
  import irq_post_clr_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned NS = N_SRC,
  parameter logic [AW-1:0] MY_ADDR = REG_ADDR
) (
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          post_en,
  output logic          hit,
  output logic [NS-1:0] clr_mask,
  output logic [NS-1:0] set_mask
);
  wr_op_e op;

  always_comb begin
    hit = (addr == MY_ADDR);
    op  = OP_NONE;
    if (wr && hit) begin
      op = post_en ? OP_POST : OP_CLEAR;
    end
  end

  always_comb begin
    clr_mask = '0;
    set_mask = '0;
    unique case (op)
      OP_CLEAR: clr_mask = ~wdata[NS-1:0];
      OP_POST:  set_mask = wdata[NS-1:0];
      default: begin
        clr_mask = '0;
        set_mask = '0;
      end
    endcase
  end
endmodule

// File: rtl/irq_flag_bit.sv
module irq_flag_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic sw_set,
  input  logic sw_clr,
  output logic flag
);
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = hw_set | sw_set | sw_clr;
    flag_d  = flag;
    if (hw_set || sw_set) begin
      flag_d = 1'b1;
    end else if (sw_clr) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (flag_en) begin
      flag <= flag_d;
    end
  end
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import irq_post_clr_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned NS = N_SRC
) (
  input  logic          hit,
  input  logic [NS-1:0] flags,
  output logic [DW-1:0] rdata
);
  localparam int unsigned PAD_W = DW - NS;

  always_comb begin
    rdata = '0;
    if (hit) begin
      rdata = {{PAD_W{1'b0}}, flags};
    end
  end
endmodule

// File: rtl/irq_post_clr_reg.sv
module irq_post_clr_reg
  import irq_post_clr_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned NE = N_EP,
  parameter logic [AW-1:0] MY_ADDR = REG_ADDR
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          sw_post_en,
  input  logic          wake_evt,
  input  logic [NE-1:0] ep_evt,
  output logic [NE:0]   irq_pending
);
  localparam int unsigned NS = NE + 1;

  logic          hit;
  logic [NS-1:0] clr_mask;
  logic [NS-1:0] set_mask;
  logic [NS-1:0] hw_evt;
  logic [NS-1:0] flags;

  assign hw_evt = {wake_evt, ep_evt};

  irq_wr_decode #(.AW(AW), .DW(DW), .NS(NS), .MY_ADDR(MY_ADDR)) u_dec (
    .addr     (bus_addr),
    .wr       (bus_wr),
    .wdata    (bus_wdata),
    .post_en  (sw_post_en),
    .hit      (hit),
    .clr_mask (clr_mask),
    .set_mask (set_mask)
  );

  for (genvar i = 0; i < NS; i++) begin : g_flag
    irq_flag_bit u_bit (
      .clk    (clk),
      .rst_n  (rst_n),
      .hw_set (hw_evt[i]),
      .sw_set (set_mask[i]),
      .sw_clr (clr_mask[i]),
      .flag   (flags[i])
    );
  end

  irq_read_mux #(.DW(DW), .NS(NS)) u_rd (
    .hit   (hit),
    .flags (flags),
    .rdata (bus_rdata)
  );

  assign irq_pending = flags;
endmodule

// File: rtl/irq_post_clr_chk.sv
module irq_post_clr_chk #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8,
  parameter int unsigned NE = 5,
  parameter logic [AW-1:0] MY_ADDR = 8'hDC
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          sw_post_en,
  input logic          wake_evt,
  input logic [NE-1:0] ep_evt,
  input logic [NE:0]   irq_pending
);
  localparam int unsigned NS = NE + 1;
  logic [NS-1:0] evt;
  logic          wr_hit;
  assign evt    = {wake_evt, ep_evt};
  assign wr_hit = bus_wr && (bus_addr == MY_ADDR);

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DW-1:NS] == '0);

  assert_read_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == MY_ADDR) |-> bus_rdata[NS-1:0] == irq_pending);

  assert_read_other_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != MY_ADDR) |-> bus_rdata == '0);

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !sw_post_en) |=>
      ((irq_pending & ~$past(evt)) & ~$past(bus_wdata[NS-1:0])) == '0);

  assert_post_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && sw_post_en) |=>
      (irq_pending & $past(bus_wdata[NS-1:0])) == $past(bus_wdata[NS-1:0]));

  assert_evt_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> (irq_pending & $past(evt)) == $past(evt));

  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit && evt == '0) |=> $stable(irq_pending));
endmodule

bind irq_post_clr_reg irq_post_clr_chk #(.AW(AW), .DW(DW), .NE(NE), .MY_ADDR(MY_ADDR)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_wr      (bus_wr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .sw_post_en  (sw_post_en),
  .wake_evt    (wake_evt),
  .ep_evt      (ep_evt),
  .irq_pending (irq_pending)
);

// File: tb/irq_post_clr_reg_bench.sv
module irq_post_clr_reg_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [7:0] RA = 8'hDC;

  logic       clk;
  logic       rst_n;
  logic [7:0] bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       sw_post_en;
  logic       wake_evt;
  logic [4:0] ep_evt;
  logic [5:0] irq_pending;

  int n_cmp;
  int n_bad;
  int model;
  int cyc;

  irq_post_clr_reg u_irq_post_clr_reg (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .sw_post_en  (sw_post_en),
    .wake_evt    (wake_evt),
    .ep_evt      (ep_evt),
    .irq_pending (irq_pending)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // behavioural reference: update at each rising edge from the inputs seen
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model = 0;
    else begin
      int m;
      int ev;
      m  = model;
      ev = {26'd0, wake_evt, ep_evt};
      if (bus_wr && bus_addr == RA) begin
        if (sw_post_en) m = m | (bus_wdata & 8'h3F);
        else            m = m & (bus_wdata & 8'h3F);
      end
      model = (m | ev) & 8'h3F;
    end
  end

  // compare every cycle on the falling edge (R10 and R3)
  always @(negedge clk) begin
    if (rst_n) begin
      check("R10", irq_pending, model);
      if (bus_addr == RA) check("R3", bus_rdata, model);
      else                check("R3", bus_rdata, 0);
    end
  end

  task automatic cyc_drive(input logic [7:0] a, input logic w, input logic [7:0] d,
                           input logic pe, input logic [5:0] ev);
    bus_addr = a; bus_wr = w; bus_wdata = d; sw_post_en = pe;
    wake_evt = ev[5]; ep_evt = ev[4:0];
    @(posedge clk); #1;
    bus_wr = 1'b0; wake_evt = 1'b0; ep_evt = '0;
  endtask

  initial begin
    n_cmp = 0; n_bad = 0;
    rst_n = 1'b0; bus_addr = RA; bus_wr = 0; bus_wdata = 0;
    sw_post_en = 0; wake_evt = 0; ep_evt = 0;
    #(CLK_PERIOD*2);
    check("R1", irq_pending, 0);
    check("R1", bus_rdata, 0);
    @(negedge clk); rst_n = 1'b1;
    // R7: post 0x15 in post mode (bits 0,2,4)
    cyc_drive(RA, 1, 8'h15, 1, 0);
    #2 check("R7", irq_pending, 6'h15);
    // R6: post-mode write of zeros leaves flags
    cyc_drive(RA, 1, 8'h00, 1, 0);
    #2 check("R6", irq_pending, 6'h15);
    // R5: clear-mode write of all ones leaves flags
    cyc_drive(RA, 1, 8'hFF, 0, 0);
    #2 check("R5", irq_pending, 6'h15);
    // R4: clear mode, write 0x3B clears bit 2 only
    cyc_drive(RA, 1, 8'h3B, 0, 0);
    #2 check("R4", irq_pending, 6'h11);
    // R2: writing ones to bits 7,6 in post mode, wake is bit 5
    cyc_drive(RA, 1, 8'hE0, 1, 0);
    #2 check("R2", bus_rdata, 8'h31);
    // R9: write at other address
    cyc_drive(8'hDD, 1, 8'h00, 0, 0);
    #2 check("R9", irq_pending, 6'h31);
    cyc_drive(8'h5C, 1, 8'h3F, 1, 0);
    #2 check("R9", irq_pending, 6'h31);
    // R8: event meets full clear on same bit; event wins
    cyc_drive(RA, 1, 8'h00, 0, 6'h21);
    #2 check("R8", irq_pending, 6'h21);
    // R8: event alone
    cyc_drive(8'h00, 0, 8'h00, 0, 6'h02);
    #2 check("R8", irq_pending, 6'h23);
    // R3: reads do not alter flags
    for (int k = 0; k < 4; k++) cyc_drive(RA, 0, 8'h00, k[0], 0);
    #2 check("R3", bus_rdata, 8'h23);
    // mixed pattern sweep
    for (int k = 0; k < 40; k++)
      cyc_drive((k % 5 == 0) ? 8'hDE : RA, k[0], 8'((k * 37) ^ 8'hA5), k[1],
                6'((k % 7 == 0) ? (1 << (k % 6)) : 0));
    repeat (2) @(posedge clk);
    #2;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    cyc = 0;
    while (cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    n_bad++; n_cmp++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule